// File: doc/BRIEF.md
# Retire-Stage Squash Arbiter

This block sits at the retire end of a multithreaded out-of-order pipeline. Each cycle, for each hardware thread on its own, it decides whether a squash takes place and at which sequence number. A squash can come from three sources: a trap that has waited out its programmable latency, a thread-context squash pulse, or an execute-stage redirect. The execute-stage redirect carries a sequence number, an include-self flag, a mispredict flag and branch-direction information.

The block keeps three pieces of state per thread: the youngest sequence number dispatched into the reorder buffer, the last committed sequence number, and a status state machine. It gates an execute-stage squash by comparing its sequence number against the youngest tracked number. This way, a younger redirect can never override an older one that has already been taken. It issues a squash command to the reorder buffer and a broadcast bundle to the earlier stages.

All outputs are registered. A decision made from inputs sampled at a clock edge is visible just after that same edge. Squash commands are plain pulses with no back-pressure, because a squash cannot be deferred. The reorder buffer must absorb a command in the cycle it appears, and it reports completion through its done input.

Top module: `retire_squash_arbiter`

## Requirements
- R1: After reset, every thread status reads Idle. The status encoding is Idle=0, Running=1, ROB-squashing=2, trap-pending=3, fetch-trap-pending=4, three bits per thread with thread t at bits [3t+2:3t]. After reset, no trap is in flight, and the squash and rob-squashing outputs are 0.
- R2: A dispatch (disp_valid) in Idle or Running records disp_seq as the youngest sequence number. In Idle it also moves the thread to Running.
- R3: A trap request in Idle or Running with no trap in flight does three things: it sets trap_inflight, sets status to trap-pending and loads the latency. The trap squash is issued exactly latency+1 cycles after the request, so latency 0 fires on the next cycle. In any other case a trap request is ignored.
- R4: A trap or context squash is a full-thread squash with bc_full=1, bc_mispred=0 and bc_taken=0. Its squash point is head_seq-1 when head_valid is 1, and otherwise the last committed sequence number.
- R5: A context squash is ignored while a trap is in flight or when a trap request arrives in the same cycle.
- R6: An execute squash is accepted only when two conditions hold: the thread is not in trap-pending, and exe_seq is no greater than the youngest tracked number. Its squash point is exe_seq, or exe_seq-1 when exe_incl is set. The squash point then becomes the youngest tracked number.
- R7: An accepted squash pulses bc_squash and rob_sq_valid for one cycle. It sets bc_rob_squashing, and drives both bc_done_seq and rob_sq_seq to the squash point. The status becomes ROB-squashing.
- R8: In ROB-squashing, bc_rob_squashing stays 1 every cycle until rob_done is seen. The thread then returns to Running and bc_rob_squashing drops.
- R9: For an accepted execute squash, bc_mispred is set equal to exe_mispred. bc_taken is forced to 1 when exe_mispred and exe_uncond are both set, and otherwise follows exe_taken.
- R10: Within one thread, the sources are ranked in this order: trap firing, then trap acceptance, then context squash, then execute squash. A lower-ranked source is dropped in a cycle taken by a higher one.
- R11: A dispatch is ignored while the thread is ROB-squashing or trap-pending.
- R12: Threads are independent; a squash on one thread leaves the other's outputs and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_latency | input | LAT_W | Cycles a trap waits before its squash |
| trap_req | input | NT | Per-thread trap request pulse |
| ctx_squash | input | NT | Per-thread context squash pulse |
| exe_valid | input | NT | Execute-stage squash request |
| exe_seq | input | NT*SEQ_W | Execute squash sequence number |
| exe_incl | input | NT | Include the requesting instruction in the squash |
| exe_mispred | input | NT | Request comes from a branch mispredict |
| exe_uncond | input | NT | Mispredicted branch is unconditional |
| exe_taken | input | NT | Resolved branch direction |
| disp_valid | input | NT | Instruction written into the reorder buffer |
| disp_seq | input | NT*SEQ_W | Sequence number of the dispatched instruction |
| commit_valid | input | NT | Instruction committed |
| commit_seq | input | NT*SEQ_W | Sequence number of the committed instruction |
| head_valid | input | NT | Reorder buffer holds at least one entry |
| head_seq | input | NT*SEQ_W | Sequence number at the reorder buffer head |
| rob_done | input | NT | Reorder buffer finished squashing |
| thread_status | output | NT*3 | Per-thread status field |
| trap_inflight | output | NT | Trap waiting for its latency |
| rob_sq_valid | output | NT | Squash command to the reorder buffer |
| rob_sq_seq | output | NT*SEQ_W | Squash point for the reorder buffer |
| bc_squash | output | NT | Broadcast squash pulse |
| bc_rob_squashing | output | NT | Broadcast: reorder buffer is squashing |
| bc_done_seq | output | NT*SEQ_W | Broadcast squash point |
| bc_mispred | output | NT | Broadcast: squash was a mispredict |
| bc_taken | output | NT | Broadcast branch direction |
| bc_full | output | NT | Broadcast: full-thread squash |

## Verification
Execute redirects are tried in several forms: older than the youngest tracked number, equal to it, and one beyond it. The boundary-equal case separates a correct less-or-equal age compare from a strict one, and the one-beyond case shows that an accepted squash lowers the gate. The include-self flag is tried alone and together with an unconditional mispredict, which separates the seq-1 arithmetic and the taken override from plain pass-through. Traps are tried at latencies 2 and 0, with the head valid and with it empty; this pins the firing cycle and both full-squash point sources. Colliding requests (context with trap, execute with trap-pending, context with execute) and a dispatch arriving mid-squash show the priority order and the gating.

// File: rtl/retsq_pkg.sv
package retsq_pkg;
  typedef enum logic [2:0] {
    TS_IDLE  = 3'd0,
    TS_RUN   = 3'd1,
    TS_ROBSQ = 3'd2,
    TS_TRAP  = 3'd3,
    TS_FTRAP = 3'd4
  } tstat_e;

  localparam int STAT_W = 3;
endpackage

// File: rtl/retsq_trap_timer.sv
module retsq_trap_timer #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LAT_W-1:0] latency,
  output logic             busy,
  output logic             fire
);
  logic [LAT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy = busy_q;
  assign fire = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (fire) begin
      busy_q <= 1'b0;
    end else if (load) begin
      busy_q <= 1'b1;
      cnt_q  <= latency;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/retsq_thread_ctrl.sv
module retsq_thread_ctrl
  import retsq_pkg::*;
#(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_fire,
  input  logic             trap_busy,
  input  logic             trap_req,
  input  logic             ctx_sq,
  input  logic             exe_valid,
  input  logic [SEQ_W-1:0] exe_seq,
  input  logic             exe_incl,
  input  logic             exe_mispred,
  input  logic             exe_uncond,
  input  logic             exe_taken,
  input  logic             disp_valid,
  input  logic [SEQ_W-1:0] disp_seq,
  input  logic             commit_valid,
  input  logic [SEQ_W-1:0] commit_seq,
  input  logic             head_valid,
  input  logic [SEQ_W-1:0] head_seq,
  input  logic             rob_done,
  output logic             trap_load,
  output logic [STAT_W-1:0] status,
  output logic             sq_pulse,
  output logic [SEQ_W-1:0] sq_point,
  output logic             robsq,
  output logic             mispred,
  output logic             taken,
  output logic             full
);
  tstat_e           stat_q, stat_d;
  logic [SEQ_W-1:0] youngest_q, youngest_d;
  logic [SEQ_W-1:0] lastc_q;
  logic [SEQ_W-1:0] full_pt, exe_pt;
  logic             open_state, ctx_ok, exe_ok, take_full, take_exe;

  assign open_state = (stat_q == TS_IDLE) || (stat_q == TS_RUN);
  assign trap_load  = trap_req && !trap_busy && open_state;
  assign full_pt    = head_valid ? (head_seq - 1'b1) : lastc_q;
  assign exe_pt     = exe_incl ? (exe_seq - 1'b1) : exe_seq;
  assign ctx_ok     = ctx_sq && !trap_busy && !trap_req;
  assign exe_ok     = exe_valid && (stat_q != TS_TRAP) && (exe_seq <= youngest_q);
  assign take_full  = trap_fire || (!trap_load && ctx_ok);
  assign take_exe   = !trap_fire && !trap_load && !ctx_ok && exe_ok;

  always_comb begin
    stat_d = stat_q;
    if (take_full || take_exe) begin
      stat_d = TS_ROBSQ;
    end else if (trap_load) begin
      stat_d = TS_TRAP;
    end else begin
      case (stat_q)
        TS_ROBSQ: if (rob_done)   stat_d = TS_RUN;
        TS_IDLE:  if (disp_valid) stat_d = TS_RUN;
        default:  stat_d = stat_q;
      endcase
    end
  end

  always_comb begin
    youngest_d = youngest_q;
    if (take_full)
      youngest_d = lastc_q;
    else if (take_exe)
      youngest_d = exe_pt;
    else if (disp_valid && open_state && !trap_load)
      youngest_d = disp_seq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q     <= TS_IDLE;
      youngest_q <= '0;
      lastc_q    <= '0;
      sq_pulse   <= 1'b0;
      sq_point   <= '0;
      robsq      <= 1'b0;
      mispred    <= 1'b0;
      taken      <= 1'b0;
      full       <= 1'b0;
    end else begin
      stat_q     <= stat_d;
      youngest_q <= youngest_d;
      if (commit_valid) lastc_q <= commit_seq;
      sq_pulse   <= take_full || take_exe;
      if (take_full)     sq_point <= full_pt;
      else if (take_exe) sq_point <= exe_pt;
      robsq      <= (stat_d == TS_ROBSQ);
      mispred    <= take_exe && exe_mispred;
      taken      <= take_exe && ((exe_mispred && exe_uncond) || exe_taken);
      full       <= take_full;
    end
  end

  assign status = stat_q;
endmodule

// File: rtl/retire_squash_arbiter.sv
module retire_squash_arbiter
  import retsq_pkg::*;
#(
  parameter int NT    = 2,
  parameter int SEQ_W = 16,
  parameter int LAT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LAT_W-1:0]    trap_latency,
  input  logic [NT-1:0]       trap_req,
  input  logic [NT-1:0]       ctx_squash,
  input  logic [NT-1:0]       exe_valid,
  input  logic [NT*SEQ_W-1:0] exe_seq,
  input  logic [NT-1:0]       exe_incl,
  input  logic [NT-1:0]       exe_mispred,
  input  logic [NT-1:0]       exe_uncond,
  input  logic [NT-1:0]       exe_taken,
  input  logic [NT-1:0]       disp_valid,
  input  logic [NT*SEQ_W-1:0] disp_seq,
  input  logic [NT-1:0]       commit_valid,
  input  logic [NT*SEQ_W-1:0] commit_seq,
  input  logic [NT-1:0]       head_valid,
  input  logic [NT*SEQ_W-1:0] head_seq,
  input  logic [NT-1:0]       rob_done,
  output logic [NT*3-1:0]     thread_status,
  output logic [NT-1:0]       trap_inflight,
  output logic [NT-1:0]       rob_sq_valid,
  output logic [NT*SEQ_W-1:0] rob_sq_seq,
  output logic [NT-1:0]       bc_squash,
  output logic [NT-1:0]       bc_rob_squashing,
  output logic [NT*SEQ_W-1:0] bc_done_seq,
  output logic [NT-1:0]       bc_mispred,
  output logic [NT-1:0]       bc_taken,
  output logic [NT-1:0]       bc_full
);
  logic [NT-1:0] t_fire, t_busy, t_load, t_pulse;
  logic [NT*SEQ_W-1:0] t_point;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    retsq_trap_timer #(.LAT_W(LAT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (t_load[t]),
      .latency (trap_latency),
      .busy    (t_busy[t]),
      .fire    (t_fire[t])
    );

    retsq_thread_ctrl #(.SEQ_W(SEQ_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .trap_fire    (t_fire[t]),
      .trap_busy    (t_busy[t]),
      .trap_req     (trap_req[t]),
      .ctx_sq       (ctx_squash[t]),
      .exe_valid    (exe_valid[t]),
      .exe_seq      (exe_seq[t*SEQ_W +: SEQ_W]),
      .exe_incl     (exe_incl[t]),
      .exe_mispred  (exe_mispred[t]),
      .exe_uncond   (exe_uncond[t]),
      .exe_taken    (exe_taken[t]),
      .disp_valid   (disp_valid[t]),
      .disp_seq     (disp_seq[t*SEQ_W +: SEQ_W]),
      .commit_valid (commit_valid[t]),
      .commit_seq   (commit_seq[t*SEQ_W +: SEQ_W]),
      .head_valid   (head_valid[t]),
      .head_seq     (head_seq[t*SEQ_W +: SEQ_W]),
      .rob_done     (rob_done[t]),
      .trap_load    (t_load[t]),
      .status       (thread_status[t*3 +: 3]),
      .sq_pulse     (t_pulse[t]),
      .sq_point     (t_point[t*SEQ_W +: SEQ_W]),
      .robsq        (bc_rob_squashing[t]),
      .mispred      (bc_mispred[t]),
      .taken        (bc_taken[t]),
      .full         (bc_full[t])
    );
  end

  assign trap_inflight = t_busy;
  assign rob_sq_valid  = t_pulse;
  assign bc_squash     = t_pulse;
  assign rob_sq_seq    = t_point;
  assign bc_done_seq   = t_point;
endmodule

// File: rtl/retsq_checker.sv
module retsq_checker #(
  parameter int NT = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NT*3-1:0] thread_status,
  input logic [NT-1:0] trap_inflight,
  input logic [NT-1:0] bc_squash,
  input logic [NT-1:0] bc_rob_squashing,
  input logic [NT-1:0] bc_full,
  input logic [NT-1:0] rob_done
);
  for (genvar t = 0; t < NT; t++) begin : g_chk
    // R3: trap-pending always has a trap in flight
    a_r3_pending_has_trap: assert property (@(posedge clk) disable iff (!rst_n)
      (thread_status[t*3 +: 3] == 3'd3) |-> trap_inflight[t]);
    // R7: a squash leaves the thread ROB-squashing
    a_r7_squash_enters_robsq: assert property (@(posedge clk) disable iff (!rst_n)
      bc_squash[t] |-> ((thread_status[t*3 +: 3] == 3'd2) && bc_rob_squashing[t]));
    // R8: rob_squashing held until done is seen
    a_r8_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      ((thread_status[t*3 +: 3] == 3'd2) && !rob_done[t]) |=> bc_rob_squashing[t]);
    // R10: while trap-pending, only the full trap squash may follow
    a_r10_trap_blocks_others: assert property (@(posedge clk) disable iff (!rst_n)
      (thread_status[t*3 +: 3] == 3'd3) |=> (!bc_squash[t] || bc_full[t]));
  end
endmodule

bind retire_squash_arbiter retsq_checker #(.NT(NT)) i_retsq_checker (
  .clk              (clk),
  .rst_n            (rst_n),
  .thread_status    (thread_status),
  .trap_inflight    (trap_inflight),
  .bc_squash        (bc_squash),
  .bc_rob_squashing (bc_rob_squashing),
  .bc_full          (bc_full),
  .rob_done         (rob_done)
);

// File: tb/test_retire_squash_arbiter.sv
`timescale 1ns/1ps
module test_retire_squash_arbiter;
  localparam int NT = 2;
  localparam int SW = 16;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LW-1:0]    trap_latency = '0;
  logic [NT-1:0]    trap_req = '0, ctx_squash = '0, exe_valid = '0, exe_incl = '0;
  logic [NT-1:0]    exe_mispred = '0, exe_uncond = '0, exe_taken = '0, disp_valid = '0;
  logic [NT-1:0]    commit_valid = '0, head_valid = '0, rob_done = '0;
  logic [NT*SW-1:0] exe_seq = '0, disp_seq = '0, commit_seq = '0, head_seq = '0;
  logic [NT*3-1:0]  thread_status;
  logic [NT-1:0]    trap_inflight, rob_sq_valid, bc_squash, bc_rob_squashing;
  logic [NT-1:0]    bc_mispred, bc_taken, bc_full;
  logic [NT*SW-1:0] rob_sq_seq, bc_done_seq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  retire_squash_arbiter #(.NT(NT), .SEQ_W(SW), .LAT_W(LW)) i_retire_squash_arbiter (
    .clk(clk), .rst_n(rst_n), .trap_latency(trap_latency), .trap_req(trap_req),
    .ctx_squash(ctx_squash), .exe_valid(exe_valid), .exe_seq(exe_seq),
    .exe_incl(exe_incl), .exe_mispred(exe_mispred), .exe_uncond(exe_uncond),
    .exe_taken(exe_taken), .disp_valid(disp_valid), .disp_seq(disp_seq),
    .commit_valid(commit_valid), .commit_seq(commit_seq), .head_valid(head_valid),
    .head_seq(head_seq), .rob_done(rob_done), .thread_status(thread_status),
    .trap_inflight(trap_inflight), .rob_sq_valid(rob_sq_valid), .rob_sq_seq(rob_sq_seq),
    .bc_squash(bc_squash), .bc_rob_squashing(bc_rob_squashing), .bc_done_seq(bc_done_seq),
    .bc_mispred(bc_mispred), .bc_taken(bc_taken), .bc_full(bc_full)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // one clock; pulses are cleared after the edge, outputs sampled 2 ns later
  task automatic tick();
    @(posedge clk);
    #2;
    trap_req = '0; ctx_squash = '0; exe_valid = '0; exe_incl = '0;
    exe_mispred = '0; exe_uncond = '0; exe_taken = '0; disp_valid = '0;
    commit_valid = '0; rob_done = '0;
  endtask

  function automatic int st(input int t);
    return int'(thread_status[t*3 +: 3]);
  endfunction
  function automatic int done_of(input int t);
    return int'(bc_done_seq[t*SW +: SW]);
  endfunction

  task automatic drive_exe(input int t, input int seq, input bit incl,
                           input bit mp, input bit unc, input bit tk);
    exe_valid[t] = 1'b1; exe_seq[t*SW +: SW] = SW'(seq); exe_incl[t] = incl;
    exe_mispred[t] = mp; exe_uncond[t] = unc; exe_taken[t] = tk;
  endtask

  task automatic t_reset();
    chk("R1 status t0 idle", st(0), 0);
    chk("R1 status t1 idle", st(1), 0);
    chk("R1 no trap in flight", int'(trap_inflight), 0);
    chk("R1 no squash", int'(bc_squash), 0);
    chk("R1 no rob squashing", int'(bc_rob_squashing), 0);
  endtask

  task automatic t_dispatch();
    disp_valid[0] = 1'b1; disp_seq[0 +: SW] = 16'd20;
    tick();
    chk("R2 idle->running", st(0), 1);
    chk("R12 other thread still idle", st(1), 0);
  endtask

  task automatic t_exe();
    drive_exe(0, 15, 0, 1, 0, 0);
    tick();
    chk("R7 squash pulse", int'(bc_squash[0]), 1);
    chk("R7 rob cmd valid", int'(rob_sq_valid[0]), 1);
    chk("R7 done seq", done_of(0), 15);
    chk("R7 rob cmd seq", int'(rob_sq_seq[0 +: SW]), 15);
    chk("R7 status robsq", st(0), 2);
    chk("R9 mispred flag", int'(bc_mispred[0]), 1);
    chk("R9 taken follows input", int'(bc_taken[0]), 0);
    chk("R12 thread1 untouched", int'(bc_squash[1]), 0);
    drive_exe(0, 16, 0, 0, 0, 0);       // younger than accepted 15
    tick();
    chk("R6 younger rejected", int'(bc_squash[0]), 0);
    chk("R8 rob squashing held", int'(bc_rob_squashing[0]), 1);
    drive_exe(0, 15, 1, 1, 1, 0);       // equal, include self
    tick();
    chk("R6 equal accepted", int'(bc_squash[0]), 1);
    chk("R6 include-self point", done_of(0), 14);
    chk("R9 uncond forces taken", int'(bc_taken[0]), 1);
    disp_valid[0] = 1'b1; disp_seq[0 +: SW] = 16'd30;
    tick();
    drive_exe(0, 25, 0, 0, 0, 0);
    tick();
    chk("R11 dispatch during robsq ignored", int'(bc_squash[0]), 0);
    rob_done[0] = 1'b1;
    tick();
    chk("R8 back to running", st(0), 1);
    chk("R8 rob squashing dropped", int'(bc_rob_squashing[0]), 0);
  endtask

  task automatic t_trap_lat2();
    commit_valid[0] = 1'b1; commit_seq[0 +: SW] = 16'd40;
    head_valid[0] = 1'b1; head_seq[0 +: SW] = 16'd50;
    tick();
    trap_latency = 8'd2;
    trap_req[0] = 1'b1;
    tick();
    chk("R3 trap pending", st(0), 3);
    chk("R3 in flight", int'(trap_inflight[0]), 1);
    chk("R3 no immediate squash", int'(bc_squash[0]), 0);
    drive_exe(0, 0, 0, 1, 0, 0);
    ctx_squash[0] = 1'b1;
    tick();
    chk("R10 exe blocked by trap", int'(bc_squash[0]), 0);
    chk("R5 ctx blocked by trap", int'(bc_squash[0]), 0);
    tick();
    chk("R3 not yet fired", int'(bc_squash[0]), 0);
    tick();
    chk("R3 fires after latency+1", int'(bc_squash[0]), 1);
    chk("R4 full flag", int'(bc_full[0]), 1);
    chk("R4 head minus one", done_of(0), 49);
    chk("R4 no mispred", int'(bc_mispred[0]), 0);
    chk("R3 flight cleared", int'(trap_inflight[0]), 0);
    rob_done[0] = 1'b1;
    tick();
    chk("R8 running after trap", st(0), 1);
  endtask

  task automatic t_trap_lat0();
    trap_latency = 8'd0;
    head_valid[0] = 1'b0;
    trap_req[0] = 1'b1;
    tick();
    chk("R3 pending at lat0", st(0), 3);
    tick();
    chk("R3 lat0 fires next cycle", int'(bc_squash[0]), 1);
    chk("R4 empty uses last commit", done_of(0), 40);
    rob_done[0] = 1'b1;
    tick();
  endtask

  task automatic t_ctx_and_priority();
    disp_valid[1] = 1'b1; disp_seq[SW +: SW] = 16'd7;
    tick();
    head_valid[1] = 1'b1; head_seq[SW +: SW] = 16'd5;
    ctx_squash[1] = 1'b1;
    tick();
    chk("R5 ctx full squash", int'(bc_full[1]), 1);
    chk("R5 ctx point", done_of(1), 4);
    chk("R12 thread0 quiet", int'(bc_squash[0]), 0);
    chk("R12 thread0 status", st(0), 1);
    rob_done[1] = 1'b1;
    tick();
    ctx_squash[1] = 1'b1;
    drive_exe(1, 0, 0, 1, 0, 1);
    tick();
    chk("R10 ctx beats exe", int'(bc_full[1]), 1);
    chk("R10 no mispred on ctx win", int'(bc_mispred[1]), 0);
    chk("R4 taken cleared on full", int'(bc_taken[1]), 0);
    rob_done[1] = 1'b1;
    tick();
    trap_latency = 8'd4;
    ctx_squash[1] = 1'b1; trap_req[1] = 1'b1;
    tick();
    chk("R5 ctx dropped with trap req", int'(bc_squash[1]), 0);
    chk("R5 trap taken instead", st(1), 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_dispatch();
    t_exe();
    t_trap_lat2();
    t_trap_lat0();
    t_ctx_and_priority();
    repeat (8) tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule